// File: doc/BRIEF.md
# I2C Single-Master Bus Controller

This block is the only master on a two-wire I2C bus. It never drives a line high. It controls the clock and data lines only through two output enables, where an asserted enable pulls the line low, and it watches both lines through readback inputs. A host gives it one command at a time. The command set is: start, repeated start, byte write, byte read that ends in an acknowledge, byte read that ends in a not-acknowledge, and stop. After a write the block reports the acknowledge bit the slave returned. After a read it reports the received byte.

The bit rate comes from a half-period count in system clock cycles, so a single block can serve standard-mode and fast-mode slaves by changing that one input. A slave may slow the bus by holding the clock line low. The controller then waits, and it starts timing the high half of each clock pulse only once it actually sees the clock line high.

Byte commands leave the bus owned, with the clock held low. This lets the host chain bytes, issue a repeated start without a stop in between, or end a read burst with a not-acknowledge. If a slave refuses a written byte, a sticky flag blocks further byte transfers until the host sends a stop or a new start.

Top module: `i2c_bus_master`

## Requirements
- R1: Output enable high means the line is pulled low. A line is never driven high. After reset, both enables are low, `busy`, `done` and `nack_flag` are low, and whenever the bus is free both enables stay low.
- R2: Apart from the start and stop edges, the data enable changes only while the clock enable is asserted. It stays constant for the whole time the clock line is released.
- R3: Command 1 (start) on a free bus releases both lines, pulls data low while clock is high, then pulls clock low. The bus is left owned, with both enables asserted.
- R4: Command 2 (repeated start), or command 1 while the bus is owned, releases data with clock low, then releases clock, then makes a new start condition. No stop condition appears on the bus in between.
- R5: Command 3 (write) shifts out `cmd_wdata` MSB first on eight clocks. On the ninth clock data is released, and the line value sampled while clock is high is returned on `ack_bit` (0 = acknowledge).
- R6: Commands 4 and 5 (read) sample eight bits MSB first into `rd_data`. On the ninth clock the master pulls data low for command 4 (acknowledge) and releases it for command 5 (not-acknowledge).
- R7: Command 6 (stop) on an owned bus pulls data low with clock low, releases clock, then releases data while clock is high. Afterwards both lines are free.
- R8: Every clock-high phase lasts max(`half_div`,1) cycles, counted from the first cycle `scl_in` reads high. A clock-low phase between bits lasts one cycle more than that.
- R9: While a slave holds the clock line low after the master releases it, the controller holds its state and resumes when the line goes high. The transferred data is unaffected.
- R10: A write whose ninth-clock sample is 1 sets `nack_flag`. While the flag is set, read and write commands cause no clock activity. Commands 1, 2 and 6 clear the flag.
- R11: A command is taken when `cmd_valid` is high and `busy` and `done` are low. `busy` stays high until the command ends, and `done` pulses for one cycle at the end. A command that has nothing to do (a byte or stop on a free bus, a byte after a refused write, or opcode 0 or 7) pulses `done` one cycle after it is taken and makes no change on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see R3 to R11) |
| cmd_wdata | input | BYTE_W | Byte to send for a write |
| half_div | input | DIV_W | Clock half-period in system cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | BYTE_W | Last byte received |
| ack_bit | output | 1 | Ninth-clock sample of the last byte |
| nack_flag | output | 1 | Sticky refused-write flag |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| scl_in | input | 1 | Clock line readback |
| sda_in | input | 1 | Data line readback |

## Verification
The hardest case to reach from the ports is a slave stretching the clock while a byte is in flight. The high-phase timer has to hold off until the line really rises, and the data sampled at the end of that phase still has to be correct. The bench builds a slave model on the two wired-AND lines. The model decodes start and stop conditions, keeps a bit position, and acknowledges or sends data when asked. It can hold the clock low for a chosen number of cycles after every falling edge. One byte is written with that stretch active, and the bench compares the measured high and low widths and the total transfer time against the half-period rule.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_START     = 3'd1,
    CMD_RESTART   = 3'd2,
    CMD_WRITE     = 3'd3,
    CMD_READ_ACK  = 3'd4,
    CMD_READ_NACK = 3'd5,
    CMD_STOP      = 3'd6
  } cmd_e;

  typedef enum logic [3:0] {
    S_FREE, S_HELD,
    S_RS_REL, S_ST_SETUP, S_ST_HOLD, S_ST_LOW,
    S_SP_LOW, S_SP_HIGH, S_SP_REL,
    S_BT_SETUP, S_BT_LOW, S_BT_HIGH
  } state_e;

  // Length of one clock half in system cycles; zero is treated as one.
  function automatic int unsigned phase_cycles(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // Whether the master pulls the data line low for the current bit.
  function automatic logic bit_pull_low(input logic data_phase, input logic is_read,
                                        input logic tx_msb, input logic ack_drive);
    if (data_phase) return !is_read && !tx_msb;
    return is_read && ack_drive;
  endfunction

endpackage

// File: rtl/i2c_bm_phase_timer.sv
`timescale 1ns/1ps
module i2c_bm_phase_timer
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             expire
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = DIV_W'(phase_cycles(32'(half_div)) - 32'd1);
  assign expire   = run && (cnt == last_cnt);

  // Counter clears whenever the phase is not running, so a stalled
  // high phase restarts its count from the first cycle the line is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bm_byte_shifter.sv
`timescale 1ns/1ps
module i2c_bm_byte_shifter
  import i2c_bm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            is_read_in,
  input  logic            ack_drive_in,
  input  logic [BITS-1:0] tx_in,
  input  logic            step,
  input  logic            sample,
  output logic            pull_low,
  output logic            last_bit,
  output logic [BITS-1:0] rx_byte
);
  localparam int IDX_W = $clog2(BITS + 1);

  logic [BITS-1:0]  tx_q;
  logic [IDX_W-1:0] idx_q;
  logic             is_read_q;
  logic             ack_drive_q;

  assign last_bit = (idx_q == IDX_W'(BITS));
  assign pull_low = bit_pull_low(!last_bit, is_read_q, tx_q[BITS-1], ack_drive_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q        <= '0;
      rx_byte     <= '0;
      idx_q       <= '0;
      is_read_q   <= 1'b0;
      ack_drive_q <= 1'b0;
    end else if (load) begin
      tx_q        <= tx_in;
      idx_q       <= '0;
      is_read_q   <= is_read_in;
      ack_drive_q <= ack_drive_in;
      if (is_read_in) rx_byte <= '0;
    end else if (step && !last_bit) begin
      tx_q  <= {tx_q[BITS-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
      if (is_read_q) rx_byte <= {rx_byte[BITS-2:0], sample};
    end
  end
endmodule

// File: rtl/i2c_bus_master.sv
`timescale 1ns/1ps
module i2c_bus_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  half_div,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_bit,
  output logic              nack_flag,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in
);
  state_e state;
  cmd_e   op;
  logic   wr_op;

  // Named internal events, also observed by the bound checker.
  logic bus_free, idle_state, accept, high_wait, timed, tmr_run, tmr_expire;
  logic framing, byte_active, byte_op;
  logic sh_load, sh_step, sh_pull, sh_last;

  assign op          = cmd_e'(cmd_op);
  assign bus_free    = (state == S_FREE);
  assign idle_state  = (state == S_FREE) || (state == S_HELD);
  assign busy        = !idle_state;
  assign accept      = cmd_valid && idle_state && !done;
  assign byte_op     = (op == CMD_WRITE) || (op == CMD_READ_ACK) || (op == CMD_READ_NACK);
  assign high_wait   = (state == S_ST_SETUP) || (state == S_SP_HIGH) || (state == S_BT_HIGH);
  assign timed       = high_wait || (state == S_RS_REL) || (state == S_ST_HOLD) ||
                       (state == S_ST_LOW) || (state == S_SP_LOW) || (state == S_SP_REL) ||
                       (state == S_BT_LOW);
  assign tmr_run     = timed && (!high_wait || scl_in);
  assign framing     = (state == S_ST_HOLD) || (state == S_SP_REL);
  assign byte_active = (state == S_BT_SETUP) || (state == S_BT_LOW) || (state == S_BT_HIGH);
  assign sh_load     = accept && (state == S_HELD) && byte_op && !nack_flag;
  assign sh_step     = (state == S_BT_HIGH) && tmr_expire;

  i2c_bm_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tmr_run),
    .half_div (half_div),
    .expire   (tmr_expire)
  );

  i2c_bm_byte_shifter #(.BITS(BYTE_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (sh_load),
    .is_read_in   (op != CMD_WRITE),
    .ack_drive_in (op == CMD_READ_ACK),
    .tx_in        (cmd_wdata),
    .step         (sh_step),
    .sample       (sda_in),
    .pull_low     (sh_pull),
    .last_bit     (sh_last),
    .rx_byte      (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FREE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      done      <= 1'b0;
      ack_bit   <= 1'b0;
      nack_flag <= 1'b0;
      wr_op     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_FREE: if (accept) begin
          if (op == CMD_START || op == CMD_RESTART) state <= S_ST_SETUP;
          else                                      done  <= 1'b1;
        end
        S_HELD: if (accept) begin
          if (op == CMD_START || op == CMD_RESTART) begin
            sda_oe    <= 1'b0;
            nack_flag <= 1'b0;
            state     <= S_RS_REL;
          end else if (op == CMD_STOP) begin
            sda_oe    <= 1'b1;
            nack_flag <= 1'b0;
            state     <= S_SP_LOW;
          end else if (byte_op && !nack_flag) begin
            wr_op <= (op == CMD_WRITE);
            state <= S_BT_SETUP;
          end else begin
            done <= 1'b1;
          end
        end
        S_RS_REL:   if (tmr_expire) begin scl_oe <= 1'b0; state <= S_ST_SETUP; end
        S_ST_SETUP: if (tmr_expire) begin sda_oe <= 1'b1; state <= S_ST_HOLD;  end
        S_ST_HOLD:  if (tmr_expire) begin scl_oe <= 1'b1; state <= S_ST_LOW;   end
        S_ST_LOW:   if (tmr_expire) begin done   <= 1'b1; state <= S_HELD;     end
        S_SP_LOW:   if (tmr_expire) begin scl_oe <= 1'b0; state <= S_SP_HIGH;  end
        S_SP_HIGH:  if (tmr_expire) begin sda_oe <= 1'b0; state <= S_SP_REL;   end
        S_SP_REL:   if (tmr_expire) begin done   <= 1'b1; state <= S_FREE;     end
        S_BT_SETUP: begin sda_oe <= sh_pull; state <= S_BT_LOW; end
        S_BT_LOW:   if (tmr_expire) begin scl_oe <= 1'b0; state <= S_BT_HIGH; end
        S_BT_HIGH:  if (tmr_expire) begin
          scl_oe <= 1'b1;
          if (sh_last) begin
            ack_bit <= sda_in;
            if (wr_op && sda_in) nack_flag <= 1'b1;
            done  <= 1'b1;
            state <= S_HELD;
          end else begin
            state <= S_BT_SETUP;
          end
        end
        default: state <= S_FREE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_master_chk.sv
`timescale 1ns/1ps
module i2c_bus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic nack_flag,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_in,
  input logic bus_free,
  input logic framing,
  input logic high_wait,
  input logic tmr_expire,
  input logic byte_active
);
  AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> (!scl_oe && !sda_oe)); // R1

  AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !framing) |-> $stable(sda_oe)); // R2

  AST_HIGH_PHASE_ENDS_ON_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (high_wait && tmr_expire) |-> scl_in); // R8

  AST_STRETCH_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (high_wait && !scl_in) |=> high_wait); // R9

  AST_NO_BYTE_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    nack_flag |-> !byte_active); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_BUSY_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R11
endmodule

bind i2c_bus_master i2c_bus_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .busy        (busy),
  .done        (done),
  .nack_flag   (nack_flag),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .scl_in      (scl_in),
  .bus_free    (bus_free),
  .framing     (framing),
  .high_wait   (high_wait),
  .tmr_expire  (tmr_expire),
  .byte_active (byte_active)
);

// File: tb/sim_i2c_bus_master.sv
`timescale 1ns/1ps
module sim_i2c_bus_master;
  localparam int DIV_W = 16;
  localparam int BW    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [BW-1:0] cmd_wdata = '0;
  logic [DIV_W-1:0] half_div = 16'd6;
  logic          busy, done, ack_bit, nack_flag, scl_oe, sda_oe;
  logic [BW-1:0] rd_data;
  logic          scl_in, sda_in;

  // Slave model and bus monitor state
  int       bitn = -1;
  logic     sl_mode = 1'b0;   // 0: receiving from master, 1: sending to master
  logic     sl_ack  = 1'b1;   // acknowledge bytes it receives
  logic     sl_quiet = 1'b0;
  logic [7:0] sl_tx = 8'h00;
  int       hold_cnt = 0, stretch_len = 0;
  logic     p_scl = 1'b1, p_sda = 1'b1;
  int       starts = 0, stops = 0, falls = 0;
  int       hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
  logic [7:0] mon_byte = 8'h00;
  logic     mon_ninth = 1'b0;
  logic     sl_pull;

  int checks = 0, failures = 0, cycles = 0;

  always_comb begin
    sl_pull = 1'b0;
    if (bitn >= 0 && bitn <= 8) begin
      if (sl_mode) sl_pull = (bitn < 8) && !sl_quiet && !sl_tx[7 - bitn];
      else         sl_pull = (bitn == 8) && sl_ack;
    end
  end

  assign scl_in = !(scl_oe || (hold_cnt > 0));
  assign sda_in = !(sda_oe || sl_pull);

  i2c_bus_master #(.DIV_W(DIV_W), .BYTE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .half_div(half_div), .busy(busy), .done(done),
    .rd_data(rd_data), .ack_bit(ack_bit), .nack_flag(nack_flag),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
  );

  always @(posedge clk) begin
    p_scl <= scl_in;
    p_sda <= sda_in;
    if (p_scl && scl_in && p_sda && !sda_in) begin
      starts <= starts + 1; bitn <= -1; sl_quiet <= 1'b0;
    end else if (p_scl && scl_in && !p_sda && sda_in) begin
      stops <= stops + 1; bitn <= -1;
    end
    if (scl_in) begin
      if (!p_scl) begin
        hi_cnt <= 1; last_lo <= lo_cnt;
        if (bitn >= 0 && bitn < 8) mon_byte <= {mon_byte[6:0], sda_in};
        if (bitn == 8) begin
          mon_ninth <= sda_in;
          if (sl_mode && sda_in) sl_quiet <= 1'b1;
        end
      end else hi_cnt <= hi_cnt + 1;
    end else begin
      if (p_scl) begin
        lo_cnt <= 1; last_hi <= hi_cnt; falls <= falls + 1;
        bitn <= (bitn == 8) ? 0 : bitn + 1;
      end else lo_cnt <= lo_cnt + 1;
    end
    if (p_scl && !scl_in && stretch_len > 0) hold_cnt <= stretch_len;
    else if (hold_cnt > 0)                   hold_cnt <= hold_cnt - 1;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] wd, output int cyc);
    @(negedge clk);
    cmd_op = op; cmd_wdata = wd; cmd_valid = 1'b1; cyc = 0;
    @(negedge clk);
    cmd_valid = 1'b0; cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done) chk("R11 command never completed", 1'b0, 0, 1);
    chk("R11 done with busy low", !busy, busy, 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // op[20:18] wdata[17:10] slave_mode[9] slave_tx[8:1] slave_ack[0]
  localparam logic [20:0] VEC [0:7] = '{
    {3'd1, 8'h00, 1'b0, 8'h00, 1'b1},
    {3'd3, 8'hA4, 1'b0, 8'h00, 1'b1},
    {3'd3, 8'h3C, 1'b0, 8'h00, 1'b1},
    {3'd2, 8'h00, 1'b0, 8'h00, 1'b1},
    {3'd3, 8'hA5, 1'b0, 8'h00, 1'b1},
    {3'd4, 8'h00, 1'b1, 8'h96, 1'b1},
    {3'd5, 8'h00, 1'b1, 8'h5A, 1'b1},
    {3'd6, 8'h00, 1'b0, 8'h00, 1'b1}
  };

  initial begin
    int cyc, s0, p0, f0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 scl_oe after reset", scl_oe == 0, scl_oe, 0);
    chk("R1 sda_oe after reset", sda_oe == 0, sda_oe, 0);
    chk("R1 busy/done/nack after reset", {busy, done, nack_flag} == 3'b000,
        {busy, done, nack_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lines high when free", scl_in && sda_in, {scl_in, sda_in}, 3);

    // R11: byte and stop commands on a free bus do nothing
    f0 = falls; p0 = stops;
    issue(3'd3, 8'h11, cyc);
    chk("R11 write on free bus done after one cycle", cyc == 1, cyc, 1);
    issue(3'd6, 8'h00, cyc);
    chk("R11 stop on free bus done after one cycle", cyc == 1, cyc, 1);
    @(negedge clk);
    chk("R11 free bus untouched", falls == f0 && stops == p0, falls - f0, 0);

    // Vector walk: full write/restart/read/stop transaction
    for (int i = 0; i < 8; i++) begin
      logic [2:0] op;
      logic [7:0] wd;
      op = VEC[i][20:18]; wd = VEC[i][17:10];
      @(negedge clk);
      sl_mode = VEC[i][9]; sl_tx = VEC[i][8:1]; sl_ack = VEC[i][0];
      s0 = starts; p0 = stops;
      issue(op, wd, cyc);
      @(negedge clk);
      case (op)
        3'd1: begin
          chk("R3 one start condition", starts == s0 + 1, starts - s0, 1);
          chk("R3 bus held low after start", scl_oe && sda_oe, {scl_oe, sda_oe}, 3);
        end
        3'd2: begin
          chk("R4 restart gives a start", starts == s0 + 1, starts - s0, 1);
          chk("R4 no stop in restart", stops == p0, stops - p0, 0);
        end
        3'd3: begin
          chk("R5 byte on bus MSB first", mon_byte == wd, mon_byte, wd);
          chk("R5 ack_bit reports slave ack", ack_bit == !VEC[i][0], ack_bit, !VEC[i][0]);
          chk("R8 high width", last_hi == 6, last_hi, 6);
          chk("R8 low width before ninth clock", last_lo == 7, last_lo, 7);
        end
        3'd4, 3'd5: begin
          chk("R6 received byte", rd_data == VEC[i][8:1], rd_data, VEC[i][8:1]);
          chk("R6 master ninth bit", mon_ninth == (op == 3'd5), mon_ninth, op == 3'd5);
        end
        default: begin
          chk("R7 one stop condition", stops == p0 + 1, stops - p0, 1);
          chk("R7 lines released", !scl_oe && !sda_oe && scl_in && sda_in,
              {scl_oe, sda_oe}, 0);
        end
      endcase
    end

    // R8: other divider values, including zero
    sl_mode = 1'b0; sl_ack = 1'b1;
    half_div = 16'd3;
    issue(3'd1, 8'h00, cyc);
    issue(3'd3, 8'hC3, cyc);
    @(negedge clk);
    chk("R8 high width at div 3", last_hi == 3, last_hi, 3);
    chk("R8 low width at div 3", last_lo == 4, last_lo, 4);
    half_div = 16'd0;
    issue(3'd3, 8'h0F, cyc);
    @(negedge clk);
    chk("R8 high width at div 0", last_hi == 1, last_hi, 1);
    chk("R8 low width at div 0", last_lo == 2, last_lo, 2);
    chk("R5 byte at fastest rate", mon_byte == 8'h0F, mon_byte, 8'h0F);

    // R9: slave stretches every low phase by 40 cycles
    half_div = 16'd6;
    stretch_len = 40;
    issue(3'd3, 8'h81, cyc);
    @(negedge clk);
    chk("R9 byte intact under stretch", mon_byte == 8'h81, mon_byte, 8'h81);
    chk("R9 ack intact under stretch", ack_bit == 1'b0, ack_bit, 0);
    chk("R9 high phase timed after release", last_hi == 6, last_hi, 6);
    chk("R9 low phase extended", last_lo >= 40, last_lo, 40);
    chk("R9 transfer slowed", cyc >= 8 * 40, cyc, 8 * 40);
    stretch_len = 0;

    // R10: refused write, blocked bytes, cleared by restart and stop
    sl_ack = 1'b0;
    issue(3'd3, 8'h20, cyc);
    chk("R10 refused write sets flag", nack_flag == 1'b1, nack_flag, 1);
    chk("R10 ack_bit shows refusal", ack_bit == 1'b1, ack_bit, 1);
    @(negedge clk);
    f0 = falls;
    issue(3'd3, 8'h55, cyc);
    chk("R10 write blocked after refusal", cyc == 1, cyc, 1);
    issue(3'd4, 8'h00, cyc);
    @(negedge clk);
    chk("R10 no clocks while flag set", falls == f0, falls - f0, 0);
    chk("R10 flag stays set", nack_flag == 1'b1, nack_flag, 1);
    issue(3'd2, 8'h00, cyc);
    chk("R10 restart clears flag", nack_flag == 1'b0, nack_flag, 0);
    issue(3'd3, 8'h40, cyc);
    chk("R10 second refusal", nack_flag == 1'b1, nack_flag, 1);
    p0 = stops;
    issue(3'd6, 8'h00, cyc);
    @(negedge clk);
    chk("R10 stop clears flag", nack_flag == 1'b0, nack_flag, 0);
    chk("R7 stop after refusal", stops == p0 + 1, stops - p0, 1);
    issue(3'd7, 8'h00, cyc);
    chk("R11 unused opcode done after one cycle", cyc == 1, cyc, 1);
    chk("R2 R1 bus free at end", !scl_oe && !sda_oe, {scl_oe, sda_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule